// File: doc/BRIEF.md
# Folded FIR Filter

This block is a finite impulse response filter whose tap products are spread over time instead of being computed all at once. A delay line holds the most recent `TAPS` input samples, and a register array holds one coefficient per tap. When a sample is accepted, the block runs `FOLD` computation stages in sequence. Each stage multiplies `TAPS/FOLD` taps by their coefficients, adds those products together, and folds the result into a running accumulator. After the final stage, the finished sum appears on the output with a one-cycle valid strobe.

The fold factor sets the balance between area and throughput. With `FOLD = 1`, every tap has its own multiplier and a new sample can enter on every cycle. Larger fold factors divide the multiplier count by `FOLD` and reduce the sample rate by the same factor. Coefficients are written one at a time through an address, data and write-enable port. The accumulator is wide enough that no sum of products can ever wrap.

Top module: `fir_fold_filter`

## Requirements
- R1: Coefficient address k weights the k-th most recent accepted sample. Address 0 weights the newest sample, so each output equals the sum over k of coef[k] * x[n-k].
- R2: Samples and coefficients are `DATA_W`/`COEF_W`-bit signed two's complement (default 18). The output is a signed value of 36 + ceil(log2(TAPS)) bits and is exact for every input, including all-minimum operands.
- R3: One output is formed in `FOLD` stages numbered 0 to `FOLD`-1, which are taken in order. Each stage uses `TAPS/FOLD` multipliers. The accumulator is loaded at stage 0 and added to at every later stage.
- R4: `outValid` is high for exactly one cycle. That cycle follows the `FOLD`-th rising edge after the edge that accepted the sample.
- R5: A sample is accepted when the block is idle or is in its last stage. This allows one new sample every `FOLD` cycles.
- R6: A sample offered while a stage other than the last is running is discarded. It changes neither the delay line nor the current or later outputs.
- R7: A high `coefWe` at a rising edge stores `coefData` at `coefAddr`. Every stage that runs after that edge uses the new value.
- R8: Reset clears the delay line, the coefficients, the accumulator and `outData`, and holds `outValid` low. Early outputs therefore reflect only the samples received since reset.
- R9: `outData` keeps the last result until the next result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | Offers `sampleData` this cycle |
| sampleData | input | DATA_W | Signed input sample |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | ADDR_W | Tap index of the coefficient to write |
| coefData | input | COEF_W | Signed coefficient value |
| outValid | output | 1 | One-cycle strobe marking a new result |
| outData | output | ACC_W | Signed filter result, held between strobes |

## Verification
The assertions assume that `rstN` is held low for at least one edge before any activity. They also assume that `sampleValid` is the only thing that starts a computation, so every stage sequence they follow begins with an accepted sample. The stimulus writes coefficients only while the block is idle. This keeps each expected output tied to a single, stable coefficient set. Samples are offered either on the exact acceptance cycle or, on purpose, on a non-final stage to exercise the discard rule. The bench uses a 16-tap, 4-stage configuration, which keeps full sweeps of impulse, extreme-value and pseudo-random sequences short.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;

  // Strobes from the stage sequencer to the datapath.
  typedef struct packed {
    logic shift;   // accept sample: shift the delay line
    logic active;  // a stage is being computed this cycle
    logic first;   // stage 0: accumulator is loaded, not added to
    logic last;    // final stage: result register is loaded
  } fir_ctrl_t;

endpackage

// File: rtl/fir_fold_ctrl.sv
module fir_fold_ctrl
  import fir_fold_pkg::*;
#(
  parameter int FOLD    = 8,
  parameter int STAGE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  output fir_ctrl_t          ctrl,
  output logic [STAGE_W-1:0] stageIdx,
  output logic               outValid
);

  localparam logic [STAGE_W-1:0] LastStage = STAGE_W'(FOLD - 1);

  logic busy;
  logic onLast;
  logic accept;

  assign onLast = busy && (stageIdx == LastStage);
  assign accept = sampleValid && (!busy || onLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      stageIdx <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= onLast;
      if (accept) begin
        busy     <= 1'b1;
        stageIdx <= '0;
      end else if (onLast) begin
        busy     <= 1'b0;
        stageIdx <= '0;
      end else if (busy) begin
        stageIdx <= stageIdx + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.shift  = accept;
    ctrl.active = busy;
    ctrl.first  = busy && (stageIdx == '0);
    ctrl.last   = onLast;
  end

endmodule

// File: rtl/fir_fold_datapath.sv
module fir_fold_datapath
  import fir_fold_pkg::*;
#(
  parameter int TAPS    = 64,
  parameter int FOLD    = 8,
  parameter int DATA_W  = 18,
  parameter int COEF_W  = 18,
  parameter int ACC_W   = 42,
  parameter int ADDR_W  = 6,
  parameter int STAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fir_ctrl_t                ctrl,
  input  logic [STAGE_W-1:0]       stageIdx,
  input  logic signed [DATA_W-1:0] sampleData,
  input  logic                     coefWe,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic signed [ACC_W-1:0]  outData
);

  localparam int LANES  = TAPS / FOLD;
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] tapReg   [TAPS];
  logic signed [COEF_W-1:0] coefReg  [TAPS];
  logic signed [PROD_W-1:0] laneProd [LANES];
  logic signed [ACC_W-1:0]  stageSum;
  logic signed [ACC_W-1:0]  nextAcc;
  logic signed [ACC_W-1:0]  accReg;
  logic signed [ACC_W-1:0]  resultReg;

  // Delay line: index 0 holds the newest sample.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) tapReg[i] <= '0;
    end else if (ctrl.shift) begin
      tapReg[0] <= sampleData;
      for (int i = 1; i < TAPS; i++) tapReg[i] <= tapReg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) coefReg[i] <= '0;
    end else if (coefWe) begin
      coefReg[coefAddr] <= coefData;
    end
  end

  // One multiplier per lane; the stage index picks which slice of taps it sees.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      laneProd[l] = tapReg[int'(stageIdx) * LANES + l]
                  * coefReg[int'(stageIdx) * LANES + l];
    end
  end

  always_comb begin
    stageSum = '0;
    for (int l = 0; l < LANES; l++) stageSum = stageSum + ACC_W'(laneProd[l]);
    nextAcc = ctrl.first ? stageSum : accReg + stageSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg    <= '0;
      resultReg <= '0;
    end else begin
      if (ctrl.active) accReg    <= nextAcc;
      if (ctrl.last)   resultReg <= nextAcc;
    end
  end

  assign outData = resultReg;

endmodule

// File: rtl/fir_fold_filter.sv
module fir_fold_filter
  import fir_fold_pkg::*;
#(
  parameter int TAPS   = 64,
  parameter int FOLD   = 8,
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  localparam int ADDR_W  = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ACC_W   = DATA_W + COEF_W + ((TAPS > 1) ? $clog2(TAPS) : 1),
  localparam int STAGE_W = (FOLD > 1) ? $clog2(FOLD) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleData,
  input  logic                     coefWe,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  fir_ctrl_t          ctrl;
  logic [STAGE_W-1:0] stageIdx;

  fir_fold_ctrl #(.FOLD(FOLD), .STAGE_W(STAGE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .ctrl(ctrl), .stageIdx(stageIdx), .outValid(outValid)
  );

  fir_fold_datapath #(
    .TAPS(TAPS), .FOLD(FOLD), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .STAGE_W(STAGE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stageIdx(stageIdx),
    .sampleData(sampleData), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .outData(outData)
  );

endmodule

// File: rtl/fir_fold_filter_check.sv
module fir_fold_filter_check
  import fir_fold_pkg::*;
#(
  parameter int STAGE_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleValid,
  input fir_ctrl_t          ctrl,
  input logic [STAGE_W-1:0] stageIdx,
  input logic               outValid
);

  // R4: the final stage is followed by exactly one output strobe
  a_r4_valid_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && ctrl.last) |=> outValid);

  // R4: no strobe without a final stage just before it
  a_r4_valid_needs_last: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(ctrl.active && ctrl.last));

  // R3: non-final stages advance by one, in order
  a_r3_stage_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !ctrl.last) |=> (ctrl.active && stageIdx == $past(stageIdx) + 1'b1));

  // R5: an offered sample on an idle or final cycle starts stage 0
  a_r5_accept_restart: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (!ctrl.active || ctrl.last)) |=> (ctrl.active && ctrl.first));

  // R6: an offer during a non-final stage never shifts the delay line
  a_r6_drop_busy: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ctrl.active && !ctrl.last) |-> !ctrl.shift);

endmodule

bind fir_fold_filter fir_fold_filter_check #(.STAGE_W(STAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .ctrl(ctrl),
  .stageIdx(stageIdx), .outValid(outValid)
);

// File: tb/fir_fold_filter_test.sv
module fir_fold_filter_test;

  localparam int T  = 16;
  localparam int F  = 4;
  localparam int DW = 18;
  localparam int AW = $clog2(T);
  localparam int OW = 36 + $clog2(T);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 sampleValid = 1'b0;
  logic signed [DW-1:0] sampleData = '0;
  logic                 coefWe = 1'b0;
  logic [AW-1:0]        coefAddr = '0;
  logic signed [DW-1:0] coefData = '0;
  logic                 outValid;
  logic signed [OW-1:0] outData;

  always #2 clk = ~clk;

  fir_fold_filter #(.TAPS(T), .FOLD(F), .DATA_W(DW), .COEF_W(DW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData)
  );

  int nTests = 0;
  int nFail  = 0;
  longint hist [T];
  longint coefM[T];
  longint pat  [T];
  longint samp [40];
  int unsigned rng = 32'h1234_5678;

  task automatic checkVal(string tag, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint modelOut();
    longint s = 0;
    for (int k = 0; k < T; k++) s += coefM[k] * hist[k];
    return s;
  endfunction

  function automatic void pushModel(longint v);
    for (int k = T - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
  endfunction

  function automatic longint nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return longint'($signed(rng[17:0]));
  endfunction

  // R7: write every coefficient from pat while idle
  task automatic loadCoefs();
    for (int k = 0; k < T; k++) begin
      @(negedge clk);
      coefWe = 1'b1; coefAddr = AW'(k); coefData = DW'(pat[k]);
      coefM[k] = pat[k];
    end
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  // Feed n samples at the full rate of one per F cycles and check every result.
  task automatic stream(int n, string tag);
    longint expPrev = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1; sampleData = DW'(samp[i]);
      @(negedge clk);
      sampleValid = 1'b0;
      if (i > 0) begin
        checkVal({tag, " R4 R5 strobe"}, longint'(outValid), 1);
        checkVal({tag, " R1 value"}, longint'(outData), expPrev);
      end
      pushModel(samp[i]);
      expPrev = modelOut();
      repeat (F - 2) @(negedge clk);
      checkVal({tag, " R4 no strobe mid-computation"}, longint'(outValid), 0);
    end
    repeat (2) @(negedge clk);
    checkVal({tag, " R4 final strobe"}, longint'(outValid), 1);
    checkVal({tag, " R1 final value"}, longint'(outData), expPrev);
    @(negedge clk);
    checkVal({tag, " R4 strobe one cycle"}, longint'(outValid), 0);
    checkVal({tag, " R9 value held"}, longint'(outData), expPrev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < T; k++) begin hist[k] = 0; coefM[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    checkVal("R8 outValid after reset", longint'(outValid), 0);
    checkVal("R8 outData after reset", longint'(outData), 0);

    // R8: coefficients cleared by reset give zero outputs
    for (int i = 0; i < 3; i++) samp[i] = 1000 * (i + 1);
    stream(3, "zero-coef");

    // R1 R7: impulse read-out of a ramp of coefficients
    for (int k = 0; k < T; k++) hist[k] = 0;
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < T; k++) coefM[k] = 0;
    for (int k = 0; k < T; k++) pat[k] = k + 1;
    loadCoefs();
    samp[0] = 1000;
    for (int i = 1; i < T + 2; i++) samp[i] = 0;
    stream(T + 2, "impulse");

    // R2: extreme operands, largest positive and most negative sums
    for (int k = 0; k < T; k++) pat[k] = -131072;
    loadCoefs();
    for (int i = 0; i < T; i++) samp[i] = -131072;
    stream(T, "max-pos");
    for (int k = 0; k < T; k++) pat[k] = 131071;
    loadCoefs();
    stream(T, "max-neg");

    // R1 R3: pseudo-random coefficients and samples
    for (int k = 0; k < T; k++) pat[k] = nextRand();
    loadCoefs();
    for (int i = 0; i < 36; i++) samp[i] = nextRand();
    stream(36, "random");

    // R6: offer a second sample during stage 0; it must be discarded
    for (int r = 0; r < 3; r++) begin
      longint keep = nextRand();
      longint junk = nextRand();
      @(negedge clk);
      sampleValid = 1'b1; sampleData = DW'(keep);
      @(negedge clk);
      sampleData = DW'(junk);
      @(negedge clk);
      sampleValid = 1'b0;
      pushModel(keep);
      repeat (F - 1) @(negedge clk);
      checkVal("R6 strobe after dropped offer", longint'(outValid), 1);
      checkVal("R6 value ignores dropped sample", longint'(outData), modelOut());
      @(negedge clk);
      checkVal("R6 no extra strobe", longint'(outValid), 0);
    end
    for (int i = 0; i < 4; i++) samp[i] = nextRand();
    stream(4, "after-drop R6");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule